// File: doc/BRIEF.md
# Sequenced Two-Register Datapath with Scratch Spill

This block evaluates the product of the sum and the difference of two operands, (A+B)·(A−B), on a datapath with only two working registers, X and Y. There is room for two live values but the expression needs three. The sum is therefore parked in a small addressed scratch memory and fetched back later. A three-bit step register indexes a control table. Each table word sets the register load enables, the bus source selects, the ALU function, the scratch address and the scratch read and write strobes. The output capture is also set by the table word.

All movement goes over one shared bus. The bus has three possible sources: the external input, the ALU result and the scratch read port. Exactly one source, or none, is enabled in a cycle. The program is six steps long and loops without pause. The caller places A on the input during step LDA and B during step LDB, and reads the result one cycle after step MUL, when the valid flag pulses.

The steps and their transitions are as follows. After reset the block enters LDA(000), where the input is loaded into X. LDB(001) loads the input into Y. SUM(010) writes X+Y to scratch address 4. DIF(011) loads X−Y into X. FET(100) reads scratch address 4 into Y. MUL(101) captures X·Y on the output. Each step lasts one cycle and always advances to the next; MUL returns to LDA. The unused codes 110 and 111 fall back to LDA.

Top module: `spill_calc`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, step is 000 (LDA), result is 0 and result_vld is 0.
- R2: The step output advances 000→001→010→011→100→101 and then back to 000, one step per clock, with no stall.
- R3: The operand input is sampled only on the clock edge that ends step 000 (as A) and the edge that ends step 001 (as B). Its value in steps 010 to 101 has no effect on the result.
- R4: In the cycle after step 101, result_vld is 1 for exactly one cycle and result equals ((A+B)·(A−B)) mod 2^DATA_W.
- R5: The sum is written to scratch address 4 in step 010 and read back from address 4 in step 100. At most one bus source (input, ALU, scratch read) is active per cycle, and read and write never coincide.
- R6: The ALU function codes are 011 for add, 010 for subtract and 110 for multiply. Only these codes are issued when the ALU drives the bus.
- R7: Subtraction wraps modulo 2^DATA_W when B > A. The multiply keeps only the low DATA_W bits of the product.
- R8: Between result_vld pulses, result holds the last computed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| operand | input | DATA_W | External data; A in step 000, B in step 001 |
| result | output | DATA_W | Last computed (A+B)·(A−B) |
| result_vld | output | 1 | One-cycle pulse when result is updated |
| step | output | 3 | Current program step code |

## Verification
A wrong step value shows on the step port within one cycle. It also corrupts the result that appears at most six cycles later, because every step feeds the single output. A wrong scratch address or strobe loses the spilled sum, so the next result pulse carries a wrong product. An ALU code fault or a sampling fault shows the same way, on the next result pulse. Junk driven on the operand input in steps 010 to 101, and operand pairs where B > A or where the sum overflows, make each of these faults show up as a wrong value.

// File: rtl/spill_pkg.sv
package spill_pkg;

    localparam int SCR_AW = 3;
    localparam logic [SCR_AW-1:0] SPILL_SLOT = 3'd4;

    localparam logic [2:0] FN_NONE = 3'b000;
    localparam logic [2:0] FN_SUB  = 3'b010;
    localparam logic [2:0] FN_ADD  = 3'b011;
    localparam logic [2:0] FN_MUL  = 3'b110;

    typedef enum logic [2:0] {
        S_LDA = 3'b000,
        S_LDB = 3'b001,
        S_SUM = 3'b010,
        S_DIF = 3'b011,
        S_FET = 3'b100,
        S_MUL = 3'b101
    } step_e;

    typedef struct packed {
        logic              ld_x;
        logic              ld_y;
        logic              src_in;
        logic              src_alu;
        logic              cap_out;
        logic [2:0]        fn;
        logic [SCR_AW-1:0] addr;
        logic              rd;
        logic              wr;
    } ctrl_t;

endpackage

// File: rtl/spill_seq.sv
module spill_seq
    import spill_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output step_e state_q,
    output ctrl_t ctrl
);

    step_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_LDA;
        else        state_q <= state_d;
    end

    always_comb begin
        ctrl    = '0;
        state_d = S_LDA;
        unique case (state_q)
            S_LDA: begin
                ctrl.ld_x   = 1'b1;
                ctrl.src_in = 1'b1;
                state_d     = S_LDB;
            end
            S_LDB: begin
                ctrl.ld_y   = 1'b1;
                ctrl.src_in = 1'b1;
                state_d     = S_SUM;
            end
            S_SUM: begin
                ctrl.fn      = FN_ADD;
                ctrl.src_alu = 1'b1;
                ctrl.addr    = SPILL_SLOT;
                ctrl.wr      = 1'b1;
                state_d      = S_DIF;
            end
            S_DIF: begin
                ctrl.fn      = FN_SUB;
                ctrl.src_alu = 1'b1;
                ctrl.ld_x    = 1'b1;
                state_d      = S_FET;
            end
            S_FET: begin
                ctrl.addr = SPILL_SLOT;
                ctrl.rd   = 1'b1;
                ctrl.ld_y = 1'b1;
                state_d   = S_MUL;
            end
            S_MUL: begin
                ctrl.fn      = FN_MUL;
                ctrl.src_alu = 1'b1;
                ctrl.cap_out = 1'b1;
                state_d      = S_LDA;
            end
            default: begin
                ctrl    = '0;
                state_d = S_LDA;
            end
        endcase
    end

    // R2: fixed step order
    p_step_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_MUL) |=> (3'(state_q) == 3'($past(state_q)) + 3'd1));
    p_step_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_MUL) |=> (state_q == S_LDA));

endmodule

// File: rtl/spill_alu.sv
module spill_alu
    import spill_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [2:0]        fn,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    always_comb begin
        unique case (fn)
            FN_ADD:  y = a + b;
            FN_SUB:  y = a - b;
            FN_MUL:  y = a * b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/spill_scratch.sv
module spill_scratch #(
    parameter int DATA_W = 8,
    parameter int AW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = rd ? mem[addr] : '0;

    // R5: a read and a write never share a cycle
    p_no_rd_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd && wr));

endmodule

// File: rtl/spill_calc.sv
module spill_calc
    import spill_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result,
    output logic              result_vld,
    output logic [2:0]        step
);

    step_e             state_q;
    ctrl_t             ctrl;
    logic [DATA_W-1:0] x_q, y_q, alu_y, scr_q, bus;

    spill_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_q (state_q),
        .ctrl    (ctrl)
    );

    spill_alu #(.DATA_W(DATA_W)) u_alu (
        .fn (ctrl.fn),
        .a  (x_q),
        .b  (y_q),
        .y  (alu_y)
    );

    spill_scratch #(.DATA_W(DATA_W), .AW(SCR_AW)) u_scr (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (ctrl.addr),
        .rd    (ctrl.rd),
        .wr    (ctrl.wr),
        .wdata (bus),
        .rdata (scr_q)
    );

    // wired-OR bus: each source gated by its own enable
    always_comb begin
        bus = ({DATA_W{ctrl.src_in}}  & operand)
            | ({DATA_W{ctrl.src_alu}} & alu_y)
            | ({DATA_W{ctrl.rd}}      & scr_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q        <= '0;
            y_q        <= '0;
            result     <= '0;
            result_vld <= 1'b0;
        end else begin
            if (ctrl.ld_x)    x_q    <= bus;
            if (ctrl.ld_y)    y_q    <= bus;
            if (ctrl.cap_out) result <= bus;
            result_vld <= ctrl.cap_out;
        end
    end

    assign step = state_q;

    // R5: one bus driver at most
    p_one_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl.src_in, ctrl.src_alu, ctrl.rd}));

    // R6: ALU drives only with a defined function
    p_fn_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.src_alu |-> (ctrl.fn == FN_ADD || ctrl.fn == FN_SUB || ctrl.fn == FN_MUL));

    // R4: valid pulse only after the multiply step
    p_vld_after_mul_r4: assert property (@(posedge clk) disable iff (!rst_n)
        result_vld |-> ($past(state_q) == S_MUL));

    // R8: result changes only with a valid pulse
    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> result_vld);

endmodule

// File: tb/tb_spill_calc.sv
module tb_spill_calc;

    localparam int W = 8;
    localparam int NV = 9;

    localparam logic [W-1:0] VA [NV] = '{8'd5, 8'd3, 8'd0, 8'd255, 8'd200, 8'd16, 8'd12, 8'd7, 8'd9};
    localparam logic [W-1:0] VB [NV] = '{8'd3, 8'd5, 8'd0, 8'd1,   8'd100, 8'd0,  8'd4,  8'd7, 8'd2};
    localparam logic [W-1:0] VE [NV] = '{8'd16, 8'd240, 8'd0, 8'd0, 8'd48, 8'd0, 8'd128, 8'd0, 8'd77};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] operand = '0;
    logic [W-1:0] result;
    logic         result_vld;
    logic [2:0]   step;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    spill_calc #(.DATA_W(W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .operand    (operand),
        .result     (result),
        .result_vld (result_vld),
        .step       (step)
    );

    function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] s, d;
        s = a + b;
        d = a - b;
        return s * d;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // entered at a negedge with step==0; leaves at a negedge with step==0
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [W-1:0] expv, input string tag);
        logic [W-1:0] held;
        operand = a;
        @(negedge clk);
        operand = b;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            operand = W'($urandom);           // R3 junk outside load steps
        end
        @(negedge clk);
        check({tag, " R4 vld"}, {7'd0, result_vld}, 8'd1);
        check({tag, " R4 R5 R6 R7 R3 value"}, result, expv);
        held = result;
        operand = W'($urandom);
        if (step != 3'd0) check({tag, " R2 phase"}, {5'd0, step}, 8'd0);
    endtask

    initial begin
        #(8 * 100000);
        bad++;
        total++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 step", {5'd0, step}, 8'd0);
        check("R1 result", result, 8'd0);
        check("R1 vld", {7'd0, result_vld}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first cycle step", {5'd1 >> 1, step}, 8'd1);

        // R2 step sequence over two loops
        for (int k = 0; k < 12; k++) begin
            check("R2 step order", {5'd0, step}, 8'(((k + 1) % 6)));
            if (((k + 1) % 6) != 0)
                check("R8 vld low", {7'd0, result_vld}, 8'd0);
            @(negedge clk);
        end
        while (step != 3'd0) @(negedge clk);

        // table walk: R4, R7 (wrap and truncation)
        for (int i = 0; i < NV; i++) begin
            check("R4 table model", model(VA[i], VB[i]), VE[i]);
            run_op(VA[i], VB[i], VE[i], "table");
        end

        // R8: result held with vld low for five cycles
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R8 hold", result, VE[NV-1]);
            check("R8 vld", {7'd0, result_vld}, 8'd0);
        end
        while (step != 3'd0) @(negedge clk);

        // random operands, back to back
        for (int i = 0; i < 30; i++) begin
            logic [W-1:0] a, b;
            a = W'($urandom);
            b = W'($urandom);
            run_op(a, b, model(a, b), "random");
        end

        // R7 corners
        run_op(8'd0, 8'd255, model(8'd0, 8'd255), "R7 wrap");
        run_op(8'd128, 8'd128, model(8'd128, 8'd128), "R7 trunc");

        // R1 reset mid-program
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid step", {5'd0, step}, 8'd0);
        check("R1 mid vld", {7'd0, result_vld}, 8'd0);
        check("R1 mid result", result, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        while (step != 3'd0) @(negedge clk);
        run_op(8'd20, 8'd10, model(8'd20, 8'd10), "R1 after reset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule